// File: doc/BRIEF.md
# Floating-Point Status and Control Register Unit

This block holds the 32-bit floating-point status and control word of a processor core and carries out the instructions that read and modify it. It can copy one 4-bit field out to a condition-register field and clear that field's sticky exception flags at the same time. It can set or clear a single flag. It can overwrite a chosen set of nibbles from a 64-bit operand under an 8-bit field mask, or overwrite every nibble at once. It can also drop a 4-bit immediate into one nibble. The arithmetic that raises exceptions, trap delivery and the condition-register file all live outside this block.

The issuing pipeline presents one operation per cycle on `op_valid_i` together with its operands. The update lands on the clock edge that samples the strobe. Three summary flags are never stored as written: the enabled-exception summary, the invalid-operation summary and the first-exception flag. They are always rebuilt from the other bits. A record request copies the top nibble of the updated word to a CR1 output. A wide-form write issued while extended mode is off is refused and raises a one-cycle invalid flag.

Top module: `fpscr_unit`

## Requirements
- R1: Reset clears the status word, the CR1 output, the field output and the invalid flag.
- R2: Operation code 0 (field to CR) takes a 3-bit selector s and loads bits [4*(7-s)+3 : 4*(7-s)] of the pre-update word onto `cr_field_o` on the strobe edge.
- R3: Operation code 0 clears only the sticky exception bits of the selected nibble. These are bits 31, 28..19 and 10..8. Control bits in that nibble keep their value, and no bit of the word rises.
- R4: Operation codes 1 (clear) and 2 (set) act on register bit 31-n, where n is the 5-bit `bit_idx_i`.
- R5: A clear or set aimed at bit 30 (enabled-exception summary) or bit 29 (invalid summary) has no effect, and a set aimed at bit 2 (non-IEEE mode) has no effect.
- R6: Operation code 3 writes nibble i (bits 4i+3..4i) from the same bits of `src_i` for each enabled i. The nibble enables are `flm_i` shifted left by 8*`hi_half_i` when `all_nib_i`=0. When `all_nib_i`=1 all 8 nibbles are enabled, or all 16 in extended mode. Enabled nibbles 8..15 have no storage and change nothing.
- R7: An operation code 3 or 4 with `hi_half_i`=1 while `ext_mode_i`=0 leaves the word unchanged. It raises `illegal_o` for exactly the cycle after the strobe.
- R8: Operation code 4 writes `imm_i` into nibble index 8*`hi_half_i`+7-s, where s is `fsel_i`. An index of 8 or more changes nothing.
- R9: Bit 30 always equals the OR over the five pairs (29,7), (28,6), (27,5), (26,4), (25,3) of status bit AND enable bit.
- R10: Bit 29 always equals the OR of cause bits 24..19 and 10..8.
- R11: Bit 31 is set by any update that raises one of bits 28..19 or 10..8 from 0 to 1. Otherwise it takes the value written or cleared.
- R12: With `rec_i`=1 on an accepted operation code 1 to 4, `cr1_o` takes bits 31..28 of the updated word. Otherwise `cr1_o` and, without a strobe, the word hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | One-cycle operation strobe |
| op_sel_i | input | 3 | Operation code: 0 field to CR, 1 bit clear, 2 bit set, 3 masked write, 4 immediate write |
| ext_mode_i | input | 1 | Extended (16-nibble) mode enable |
| fsel_i | input | 3 | Field selector for codes 0 and 4 |
| bit_idx_i | input | 5 | Bit number, big-endian order, for codes 1 and 2 |
| flm_i | input | 8 | Nibble write mask for code 3 |
| all_nib_i | input | 1 | Write all nibbles (code 3) |
| hi_half_i | input | 1 | Wide-form selector for codes 3 and 4 |
| imm_i | input | 4 | Immediate nibble for code 4 |
| src_i | input | 64 | Source operand for code 3 |
| rec_i | input | 1 | Record request to CR1 |
| fpscr_o | output | 32 | Current status and control word |
| cr1_o | output | 4 | Recorded summary nibble |
| cr_field_o | output | 4 | Field copied out by code 0 |
| illegal_o | output | 1 | Invalid-form pulse |

## Verification
The bench drives a chained sequence of operations whose expected words are worked out by hand. Each check leans on state left by the one before. It reads a nibble that mixes sticky and control bits, so a design that cleared the whole nibble would lose the enables. It clears the last remaining invalid cause, so a design that stored the invalid summary instead of rebuilding it would leave bit 29 high. It aims writes at the two summary bits and the non-IEEE bit, and it issues wide forms with extended mode off and on. A design that decoded indices little-endian, let a refused write through, or failed to set or clear the first-exception flag would show a wrong word at the next check.

// File: rtl/fpscr_unit_pkg.sv
package fpscr_unit_pkg;

   typedef enum logic [2:0] {
      FS_OP_TO_CR   = 3'd0,
      FS_OP_BIT_CLR = 3'd1,
      FS_OP_BIT_SET = 3'd2,
      FS_OP_FIELD   = 3'd3,
      FS_OP_IMM     = 3'd4
   } fs_op_e;

   localparam int unsigned POS_FX  = 31;
   localparam int unsigned POS_FEX = 30;
   localparam int unsigned POS_VX  = 29;
   localparam int unsigned POS_OX  = 28;
   localparam int unsigned POS_UX  = 27;
   localparam int unsigned POS_ZX  = 26;
   localparam int unsigned POS_XX  = 25;
   localparam int unsigned POS_VE  = 7;
   localparam int unsigned POS_OE  = 6;
   localparam int unsigned POS_UE  = 5;
   localparam int unsigned POS_ZE  = 4;
   localparam int unsigned POS_XE  = 3;
   localparam int unsigned POS_NI  = 2;

   // invalid-operation cause bits: 24..19 and 10..8
   localparam logic [31:0] VX_CAUSE_MASK = 32'h01F8_0700;
   // sticky bits that can raise the first-exception flag
   localparam logic [31:0] STICKY_NOFX   = VX_CAUSE_MASK | 32'h1E00_0000;
   // sticky bits cleared by a field read, first-exception flag included
   localparam logic [31:0] STICKY_ALL    = STICKY_NOFX | 32'h8000_0000;

endpackage

// File: rtl/fpscr_update_gen.sv
module fpscr_update_gen
   import fpscr_unit_pkg::*;
#(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned NIB_W   = 4,
   parameter int unsigned SRC_W   = 64,
   parameter bit          HAS_EXT = 1'b1,
   localparam int unsigned REG_NIBS  = REG_W / NIB_W,
   localparam int unsigned ALL_NIBS  = SRC_W / NIB_W,
   localparam int unsigned FSEL_W    = $clog2(REG_NIBS),
   localparam int unsigned BIT_W     = $clog2(REG_W),
   localparam int unsigned NIB_IDX_W = $clog2(ALL_NIBS)
) (
   input  logic [2:0]          op_sel_i,
   input  logic                ext_mode_i,
   input  logic [FSEL_W-1:0]   fsel_i,
   input  logic [BIT_W-1:0]    bit_idx_i,
   input  logic [REG_NIBS-1:0] flm_i,
   input  logic                all_i,
   input  logic                hi_i,
   input  logic [NIB_W-1:0]    imm_i,
   input  logic [SRC_W-1:0]    src_i,
   input  logic [REG_W-1:0]    cur_i,
   output logic [REG_W-1:0]    raw_o,
   output logic                illegal_o,
   output logic                record_ok_o,
   output logic [NIB_W-1:0]    cr_nib_o
);

   fs_op_e op;
   assign op = fs_op_e'(op_sel_i);

   logic ext_eff;
   generate
      if (HAS_EXT) begin : g_ext
         assign ext_eff = ext_mode_i;
      end else begin : g_no_ext
         logic unused_ext;
         assign unused_ext = ext_mode_i;
         assign ext_eff    = 1'b0;
      end
   endgenerate

   // big-endian field numbering: selector s names nibble 7-s
   logic [FSEL_W-1:0] rd_idx;
   assign rd_idx   = FSEL_W'(REG_NIBS - 1) - fsel_i;
   assign cr_nib_o = cur_i[rd_idx*NIB_W +: NIB_W];

   logic [BIT_W-1:0] bit_pos;
   logic [REG_W-1:0] one_hot;
   assign bit_pos = BIT_W'(REG_W - 1) - bit_idx_i;
   assign one_hot = REG_W'(1) << bit_pos;

   logic prot_clr, prot_set;
   assign prot_clr = (bit_pos == BIT_W'(POS_FEX)) || (bit_pos == BIT_W'(POS_VX));
   assign prot_set = prot_clr || (bit_pos == BIT_W'(POS_NI));

   logic wide_bad;
   assign wide_bad = hi_i & ~ext_eff;

   logic [ALL_NIBS-1:0] fld_nmask, imm_nmask;
   logic [REG_NIBS-1:0] rd_nmask;
   logic [NIB_IDX_W-1:0] imm_idx;

   always_comb begin
      if (all_i)
         fld_nmask = ext_eff ? '1 : ALL_NIBS'({REG_NIBS{1'b1}});
      else
         fld_nmask = ALL_NIBS'(flm_i) << (hi_i ? REG_NIBS : 0);
      imm_idx   = (hi_i ? NIB_IDX_W'(REG_NIBS) : '0) + NIB_IDX_W'(REG_NIBS - 1)
                  - NIB_IDX_W'(fsel_i);
      imm_nmask = ALL_NIBS'(1) << imm_idx;
      rd_nmask  = REG_NIBS'(1) << rd_idx;
   end

   // nibbles above the stored word have no storage
   logic unused_hi;
   assign unused_hi = ^{fld_nmask[ALL_NIBS-1:REG_NIBS], imm_nmask[ALL_NIBS-1:REG_NIBS],
                        src_i[SRC_W-1:REG_W]};

   logic [REG_W-1:0] fld_bm, imm_bm, rd_bm;
   generate
      for (genvar i = 0; i < REG_NIBS; i++) begin : g_lane
         assign fld_bm[i*NIB_W +: NIB_W] = {NIB_W{fld_nmask[i]}};
         assign imm_bm[i*NIB_W +: NIB_W] = {NIB_W{imm_nmask[i]}};
         assign rd_bm[i*NIB_W +: NIB_W]  = {NIB_W{rd_nmask[i]}};
      end
   endgenerate

   always_comb begin
      raw_o       = cur_i;
      illegal_o   = 1'b0;
      record_ok_o = 1'b0;
      case (op)
         FS_OP_TO_CR:
            raw_o = cur_i & ~(rd_bm & STICKY_ALL);
         FS_OP_BIT_CLR: begin
            record_ok_o = 1'b1;
            if (!prot_clr) raw_o = cur_i & ~one_hot;
         end
         FS_OP_BIT_SET: begin
            record_ok_o = 1'b1;
            if (!prot_set) raw_o = cur_i | one_hot;
         end
         FS_OP_FIELD: begin
            illegal_o   = wide_bad;
            record_ok_o = ~wide_bad;
            if (!wide_bad) raw_o = (cur_i & ~fld_bm) | (src_i[REG_W-1:0] & fld_bm);
         end
         FS_OP_IMM: begin
            illegal_o   = wide_bad;
            record_ok_o = ~wide_bad;
            if (!wide_bad) raw_o = (cur_i & ~imm_bm) | ({REG_NIBS{imm_i}} & imm_bm);
         end
         default: raw_o = cur_i;
      endcase
   end

endmodule

// File: rtl/fpscr_summary.sv
module fpscr_summary
   import fpscr_unit_pkg::*;
#(
   parameter int unsigned REG_W = 32
) (
   input  logic [REG_W-1:0] cur_i,
   input  logic [REG_W-1:0] raw_i,
   output logic [REG_W-1:0] next_o
);

   logic [REG_W-1:0] rise;
   assign rise = raw_i & ~cur_i & STICKY_NOFX;

   always_comb begin
      next_o          = raw_i;
      next_o[POS_FX]  = raw_i[POS_FX] | (|rise);
      next_o[POS_VX]  = |(raw_i & VX_CAUSE_MASK);
      next_o[POS_FEX] = (next_o[POS_VX] & raw_i[POS_VE]) |
                        (raw_i[POS_OX]  & raw_i[POS_OE]) |
                        (raw_i[POS_UX]  & raw_i[POS_UE]) |
                        (raw_i[POS_ZX]  & raw_i[POS_ZE]) |
                        (raw_i[POS_XX]  & raw_i[POS_XE]);
   end

endmodule

// File: rtl/fpscr_unit.sv
module fpscr_unit
   import fpscr_unit_pkg::*;
#(
   parameter int unsigned REG_W   = 32,
   parameter int unsigned NIB_W   = 4,
   parameter int unsigned SRC_W   = 64,
   parameter bit          HAS_EXT = 1'b1,
   localparam int unsigned REG_NIBS = REG_W / NIB_W,
   localparam int unsigned FSEL_W   = $clog2(REG_NIBS),
   localparam int unsigned BIT_W    = $clog2(REG_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid_i,
   input  logic [2:0]          op_sel_i,
   input  logic                ext_mode_i,
   input  logic [FSEL_W-1:0]   fsel_i,
   input  logic [BIT_W-1:0]    bit_idx_i,
   input  logic [REG_NIBS-1:0] flm_i,
   input  logic                all_nib_i,
   input  logic                hi_half_i,
   input  logic [NIB_W-1:0]    imm_i,
   input  logic [SRC_W-1:0]    src_i,
   input  logic                rec_i,
   output logic [REG_W-1:0]    fpscr_o,
   output logic [NIB_W-1:0]    cr1_o,
   output logic [NIB_W-1:0]    cr_field_o,
   output logic                illegal_o
);

   generate
      if (REG_W != 32) begin : g_bad_width
         $error("fpscr_unit: bit layout needs REG_W of 32");
      end
      if (NIB_W * REG_NIBS != REG_W) begin : g_bad_nib
         $error("fpscr_unit: REG_W must be a multiple of NIB_W");
      end
      if (SRC_W < REG_W || SRC_W % NIB_W != 0) begin : g_bad_src
         $error("fpscr_unit: SRC_W must cover the word in whole nibbles");
      end
   endgenerate

   logic [REG_W-1:0] fpscr_q, raw_w, next_w;
   logic [NIB_W-1:0] cr1_q, cr_field_q, cr_nib_w;
   logic             illegal_q, illegal_w, record_ok_w, past_ok;

   fpscr_update_gen #(
      .REG_W(REG_W), .NIB_W(NIB_W), .SRC_W(SRC_W), .HAS_EXT(HAS_EXT)
   ) u_gen (
      .op_sel_i   (op_sel_i),
      .ext_mode_i (ext_mode_i),
      .fsel_i     (fsel_i),
      .bit_idx_i  (bit_idx_i),
      .flm_i      (flm_i),
      .all_i      (all_nib_i),
      .hi_i       (hi_half_i),
      .imm_i      (imm_i),
      .src_i      (src_i),
      .cur_i      (fpscr_q),
      .raw_o      (raw_w),
      .illegal_o  (illegal_w),
      .record_ok_o(record_ok_w),
      .cr_nib_o   (cr_nib_w)
   );

   fpscr_summary #(.REG_W(REG_W)) u_sum (
      .cur_i (fpscr_q),
      .raw_i (raw_w),
      .next_o(next_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fpscr_q    <= '0;
         cr1_q      <= '0;
         cr_field_q <= '0;
         illegal_q  <= 1'b0;
         past_ok    <= 1'b0;
      end else begin
         past_ok   <= 1'b1;
         illegal_q <= op_valid_i & illegal_w;
         if (op_valid_i) begin
            fpscr_q <= next_w;
            if (op_sel_i == FS_OP_TO_CR) cr_field_q <= cr_nib_w;
            if (rec_i && record_ok_w)    cr1_q      <= next_w[REG_W-1 -: NIB_W];
         end
      end
   end

   assign fpscr_o    = fpscr_q;
   assign cr1_o      = cr1_q;
   assign cr_field_o = cr_field_q;
   assign illegal_o  = illegal_q;

   p_fex_summary_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fpscr_q[POS_FEX] == ((fpscr_q[POS_VX] & fpscr_q[POS_VE]) | (fpscr_q[POS_OX] & fpscr_q[POS_OE]) |
                           (fpscr_q[POS_UX] & fpscr_q[POS_UE]) | (fpscr_q[POS_ZX] & fpscr_q[POS_ZE]) |
                           (fpscr_q[POS_XX] & fpscr_q[POS_XE])));

   p_vx_summary_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fpscr_q[POS_VX] == |(fpscr_q & VX_CAUSE_MASK));

   p_refused_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && op_valid_i && illegal_w |=> $stable(fpscr_q) && illegal_q);

   p_read_only_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && op_valid_i && (op_sel_i == FS_OP_TO_CR) |=> (fpscr_q & ~$past(fpscr_q)) == '0);

   p_fx_on_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && op_valid_i |=> (((fpscr_q & ~$past(fpscr_q) & STICKY_NOFX) == '0) || fpscr_q[POS_FX]));

   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !op_valid_i |=> $stable(fpscr_q) && $stable(cr1_q));

endmodule

// File: tb/fpscr_unit_tb.sv
module fpscr_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_valid;
   logic [2:0]  op_sel;
   logic        ext_mode;
   logic [2:0]  fsel;
   logic [4:0]  bit_idx;
   logic [7:0]  flm;
   logic        all_nib;
   logic        hi_half;
   logic [3:0]  imm;
   logic [63:0] src;
   logic        rec;
   logic [31:0] fpscr;
   logic [3:0]  cr1, cr_field;
   logic        illegal;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   fpscr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_sel_i(op_sel),
      .ext_mode_i(ext_mode), .fsel_i(fsel), .bit_idx_i(bit_idx), .flm_i(flm),
      .all_nib_i(all_nib), .hi_half_i(hi_half), .imm_i(imm), .src_i(src),
      .rec_i(rec), .fpscr_o(fpscr), .cr1_o(cr1), .cr_field_o(cr_field),
      .illegal_o(illegal)
   );

   task automatic check(input string req, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      op_valid = 0; op_sel = 0; ext_mode = 0; fsel = 0; bit_idx = 0; flm = 0;
      all_nib = 0; hi_half = 0; imm = 0; src = '0; rec = 0;
   endtask

   // strobe one operation; returns at the falling edge after the update edge
   task automatic issue(input logic [2:0] op, input logic [2:0] fs, input logic [4:0] bi,
                        input logic [7:0] fm, input logic al, input logic hi,
                        input logic ex, input logic [3:0] im, input logic [63:0] sv,
                        input logic rc);
      @(negedge clk);
      op_sel = op; fsel = fs; bit_idx = bi; flm = fm; all_nib = al; hi_half = hi;
      ext_mode = ex; imm = im; src = sv; rec = rc; op_valid = 1'b1;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "word", fpscr, 0);
      check("R1", "cr1", cr1, 0);
      check("R1", "field", cr_field, 0);
      check("R1", "illegal", illegal, 0);
   endtask

   task automatic t_write_all();
      issue(3, 0, 0, 8'h00, 1, 0, 0, 0, 64'h0000_0000_1234_5678, 1);
      check("R6", "write all nibbles", fpscr, 32'hF234_5678);
      check("R11", "first-exception flag raised", fpscr[31], 1);
      check("R12", "cr1 recorded", cr1, 4'hF);
   endtask

   task automatic t_read_clear();
      issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R2", "field 0 copy", cr_field, 4'hF);
      check("R3", "field 0 sticky cleared", fpscr, 32'h6234_5678);
      check("R12", "cr1 held without record", cr1, 4'hF);
      issue(0, 2, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R2", "field 2 copy", cr_field, 4'h3);
      check("R3", "field 2 causes cleared", fpscr, 32'h6204_5678);
      issue(0, 6, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R2", "field 6 copy", cr_field, 4'h7);
      check("R3", "control nibble kept", fpscr, 32'h6204_5678);
   endtask

   task automatic t_bit_clear();
      issue(1, 0, 21, 0, 0, 0, 0, 0, 0, 0);
      check("R4", "clear bit 10", fpscr, 32'h6204_5278);
      issue(1, 0, 22, 0, 0, 0, 0, 0, 0, 0);
      check("R10", "last cause cleared drops invalid summary", fpscr, 32'h4204_5078);
   endtask

   task automatic t_protected();
      issue(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
      check("R5", "clear of bit 30 ignored", fpscr, 32'h4204_5078);
      issue(2, 0, 2, 0, 0, 0, 0, 0, 0, 0);
      check("R5", "set of bit 29 ignored", fpscr, 32'h4204_5078);
      issue(2, 0, 29, 0, 0, 0, 0, 0, 0, 0);
      check("R5", "set of bit 2 ignored", fpscr, 32'h4204_5078);
   endtask

   task automatic t_bit_set();
      issue(2, 0, 5, 0, 0, 0, 0, 0, 0, 1);
      check("R11", "set bit 26 raises first flag", fpscr, 32'hC604_5078);
      check("R12", "cr1 after set", cr1, 4'hC);
      issue(1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      check("R4", "clear bit 31", fpscr, 32'h4604_5078);
      check("R12", "cr1 after clear", cr1, 4'h4);
   endtask

   task automatic t_masked();
      issue(3, 0, 0, 8'h02, 0, 0, 0, 0, 64'h0000_0000_0000_0080, 0);
      check("R6", "mask selects nibble 1 only", fpscr, 32'h4604_5088);
   endtask

   task automatic t_refused();
      issue(3, 0, 0, 8'hFF, 0, 1, 0, 0, 64'h0, 0);
      check("R7", "wide masked write refused", fpscr, 32'h4604_5088);
      check("R7", "illegal pulse on masked", illegal, 1);
      issue(4, 0, 0, 0, 0, 1, 0, 4'hF, 0, 0);
      check("R7", "wide immediate refused", fpscr, 32'h4604_5088);
      check("R7", "illegal pulse on immediate", illegal, 1);
   endtask

   task automatic t_immediate();
      issue(4, 7, 0, 0, 0, 0, 0, 4'h3, 0, 1);
      check("R8", "immediate into nibble 0", fpscr, 32'h0604_5083);
      check("R9", "enabled summary falls", fpscr[30], 0);
      check("R7", "illegal cleared", illegal, 0);
      check("R12", "cr1 zero", cr1, 4'h0);
      issue(4, 0, 0, 0, 0, 0, 0, 4'hF, 0, 0);
      check("R8", "immediate into nibble 7, summaries rebuilt", fpscr, 32'h9604_5083);
   endtask

   task automatic t_extended();
      issue(3, 0, 0, 8'hFF, 0, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      check("R6", "upper nibbles have no storage", fpscr, 32'h9604_5083);
      check("R7", "extended wide form accepted", illegal, 0);
      issue(4, 0, 0, 0, 0, 1, 1, 4'hF, 0, 0);
      check("R8", "immediate index 15 no effect", fpscr, 32'h9604_5083);
      issue(3, 0, 0, 8'h00, 1, 0, 1, 0, 64'hFFFF_FFFF_0000_0000, 0);
      check("R11", "field write clears first flag", fpscr, 32'h0000_0000);
   endtask

   task automatic t_summaries();
      issue(3, 0, 0, 8'h00, 1, 0, 0, 0, 64'h0000_0000_0100_0080, 1);
      check("R10", "invalid summary from cause bit 24", fpscr, 32'hE100_0080);
      check("R9", "enabled summary via bit 7", fpscr[30], 1);
      check("R12", "cr1 recorded", cr1, 4'hE);
      issue(2, 0, 4, 0, 0, 0, 0, 0, 0, 0);
      check("R4", "set bit 27", fpscr, 32'hE900_0080);
      check("R12", "cr1 held when rec low", cr1, 4'hE);
   endtask

   task automatic t_idle();
      @(negedge clk);
      src = 64'hDEAD_BEEF_DEAD_BEEF; op_sel = 3; all_nib = 1; rec = 1;
      repeat (4) @(negedge clk);
      check("R12", "word held without strobe", fpscr, 32'hE900_0080);
      check("R12", "cr1 held without strobe", cr1, 4'hE);
      idle_inputs();
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_write_all();
      t_read_clear();
      t_bit_clear();
      t_protected();
      t_bit_set();
      t_masked();
      t_refused();
      t_immediate();
      t_extended();
      t_summaries();
      t_idle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule